// File: doc/BRIEF.md
# Idle Timer and Power-Mode Controller

This block keeps a free-running cycle timer for a small microcontroller and decides when the core's clocks may run. A divider turns the oscillator clock into an instruction-cycle tick, and the timer advances by one on each tick. Whenever a selected timer bit changes level, in either direction, a pending flag is latched. Together with a software enable bit, that flag forms a timer interrupt request.

Two write strobes place the chip in a low-power state. In IDLE the core clock enable is removed, but the divider and timer keep running. IDLE ends on a wakeup request or on the next pending-flag event. In HALT the divider also stops and the timer is held at zero. After a wakeup the timer measures a fixed start-up delay before the core clock enable returns. A build option can remove HALT entirely, so that its write strobe does nothing.

The wakeup input may be asynchronous and passes through a synchronizer of at least two flops. The block raises the core clock enable and the mode flags for the rest of the chip, and accepts software strobes for the enable bit and for clearing the pending flag.

Top module: `lpm_idle_timer`

## Requirements
- R1: After reset, core_clk_en is 1, timer_q is 0, and t0_pnd, t0_en, t0_irq, idle_flag_o and halt_flag_o are all 0.
- R2: Outside HALT, tick_o is high for one clock in every DIV_RATIO clocks (10 by default), and timer_q increases by exactly 1 on the clock edge where tick_o is high.
- R3: t0_pnd becomes 1 on the same clock edge where timer_q[TOGGLE_BIT] (bit 12 by default) changes, for both a 0-to-1 and a 1-to-0 change.
- R4: A one-clock pnd_clr pulse clears t0_pnd. If a bit-12 change falls on the same edge as pnd_clr, t0_pnd ends up 1.
- R5: t0_irq is 1 exactly when t0_pnd is 1, the enable bit t0_en is 1 (written through t0en_we/t0en_wd) and core_clk_en is 1.
- R6: An idle_set pulse while running drops core_clk_en and raises idle_flag_o one edge later, and timer_q keeps advancing during IDLE.
- R7: In IDLE, a wakeup input held high raises core_clk_en on the third clock edge after it is applied. The delay is two synchronizer stages plus the state register.
- R8: In IDLE, a bit-12 change leaves IDLE on that same edge: core_clk_en and t0_pnd rise together, and t0_irq is 1 at that moment only if t0_en is 1.
- R9: With HALT enabled, a halt_set pulse while running drops core_clk_en and raises halt_flag_o one edge later. In HALT, tick_o stays 0 and timer_q is held at 0.
- R10: In HALT, a wakeup input raises core_clk_en after exactly 3 + DIV_RATIO*STARTUP_TICKS clock edges (2563 by default). halt_flag_o stays 1 until that same edge.
- R11: Built with HALT_EN = 0, a halt_set pulse has no effect: core_clk_en stays 1, halt_flag_o stays 0 and timer_q keeps advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wakeup request, asynchronous, level |
| idle_set | input | 1 | Write-one strobe that enters IDLE |
| halt_set | input | 1 | Write-one strobe that enters HALT |
| t0en_we | input | 1 | Write strobe for the timer interrupt enable |
| t0en_wd | input | 1 | Value written to the timer interrupt enable |
| pnd_clr | input | 1 | Strobe that clears the timer pending flag |
| tick_o | output | 1 | Instruction-cycle tick, one clock wide |
| timer_q | output | TMR_W | Idle timer value |
| t0_pnd | output | 1 | Timer pending flag |
| t0_en | output | 1 | Timer interrupt enable |
| t0_irq | output | 1 | Timer interrupt request |
| core_clk_en | output | 1 | Clock enable for the core and peripherals |
| idle_flag_o | output | 1 | 1 while in IDLE |
| halt_flag_o | output | 1 | 1 during HALT and its start-up delay |

## Verification
Mode strobes and pnd_clr act one edge after they are applied. A timer-bit change sets the pending flag on the same edge that moves timer_q, so those checks sample on the negative edge where the new timer value first appears. A wakeup needs three edges in IDLE and 3 + 10*256 edges out of HALT. The bench applies each stimulus just after a negative edge, counts positive edges, and samples on the negative edge that follows the expected count. The collision case is timed by waiting for the negative edge where tick_o is high and the low twelve timer bits are all ones, so the clear strobe and the bit change meet on the same edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_HALT = 2'd2,
      PM_WARM = 2'd3
   } pm_state_t;

endpackage

// File: rtl/lpm_tick_div.sv
// Divides the oscillator clock into a one-cycle instruction tick.
module lpm_tick_div #(
   parameter int DIV_RATIO = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

   generate
      if (DIV_RATIO < 2) begin : g_bad_div
         $error("lpm_tick_div: DIV_RATIO must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   assign tick = run && (cnt == LAST);

endmodule

// File: rtl/lpm_idle_tmr.sv
// Free-running idle timer with toggle-event detection, pending flag and enable.
module lpm_idle_tmr #(
   parameter int TMR_W      = 16,
   parameter int TOGGLE_BIT = 12,
   parameter int SU_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold_clr,
   input  logic             pnd_clr,
   input  logic             en_we,
   input  logic             en_wd,
   output logic [TMR_W-1:0] timer,
   output logic             toggle_evt,
   output logic             su_done,
   output logic             pnd,
   output logic             en
);
   // The watched bit flips on an increment exactly when every bit below it is 1.
   assign toggle_evt = tick && (&timer[TOGGLE_BIT-1:0]);
   assign su_done    = tick && (&timer[SU_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer <= '0;
      end else if (hold_clr) begin
         timer <= '0;
      end else if (tick) begin
         timer <= timer + TMR_W'(1);
      end
   end

   // Set event has priority over the software clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pnd <= 1'b0;
      end else if (toggle_evt) begin
         pnd <= 1'b1;
      end else if (pnd_clr) begin
         pnd <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0;
      end else if (en_we) begin
         en <= en_wd;
      end
   end

endmodule

// File: rtl/lpm_mode_seq.sv
// Power-mode sequencer: RUN, IDLE, HALT and the post-HALT warm-up.
module lpm_mode_seq
   import lpm_pkg::*;
#(
   parameter bit HALT_EN     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wake_async,
   input  logic      idle_set,
   input  logic      halt_set,
   input  logic      toggle_evt,
   input  logic      su_done,
   output pm_state_t state
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   wake_s;
   logic                   halt_req;
   pm_state_t              state_nx;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lpm_mode_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], wake_async};
      end
   end

   assign wake_s = sync_q[SYNC_STAGES-1];

   generate
      if (HALT_EN) begin : g_halt_on
         assign halt_req = halt_set;
      end else begin : g_halt_off
         logic halt_unused;
         assign halt_unused = halt_set;
         assign halt_req    = 1'b0;
      end
   endgenerate

   always_comb begin
      state_nx = state;
      unique case (state)
         PM_RUN: begin
            if (halt_req) begin
               state_nx = PM_HALT;
            end else if (idle_set) begin
               state_nx = PM_IDLE;
            end
         end
         PM_IDLE: begin
            if (wake_s || toggle_evt) begin
               state_nx = PM_RUN;
            end
         end
         PM_HALT: begin
            if (wake_s) begin
               state_nx = PM_WARM;
            end
         end
         PM_WARM: begin
            if (su_done) begin
               state_nx = PM_RUN;
            end
         end
         default: state_nx = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PM_RUN;
      end else begin
         state <= state_nx;
      end
   end

endmodule

// File: rtl/lpm_idle_timer.sv
// Top: idle timer and power-mode controller.
module lpm_idle_timer
   import lpm_pkg::*;
#(
   parameter int DIV_RATIO     = 10,
   parameter int TMR_W         = 16,
   parameter int TOGGLE_BIT    = 12,
   parameter int STARTUP_TICKS = 256,
   parameter bit HALT_EN       = 1'b1,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake_i,
   input  logic             idle_set,
   input  logic             halt_set,
   input  logic             t0en_we,
   input  logic             t0en_wd,
   input  logic             pnd_clr,
   output logic             tick_o,
   output logic [TMR_W-1:0] timer_q,
   output logic             t0_pnd,
   output logic             t0_en,
   output logic             t0_irq,
   output logic             core_clk_en,
   output logic             idle_flag_o,
   output logic             halt_flag_o
);
   localparam int SU_W = (STARTUP_TICKS > 1) ? $clog2(STARTUP_TICKS) : 1;

   generate
      if (TOGGLE_BIT >= TMR_W || TOGGLE_BIT < 1) begin : g_bad_bit
         $error("lpm_idle_timer: TOGGLE_BIT must lie inside the timer");
      end
      if ((1 << SU_W) != STARTUP_TICKS) begin : g_bad_su
         $error("lpm_idle_timer: STARTUP_TICKS must be a power of two >= 2");
      end
      if (SU_W > TOGGLE_BIT) begin : g_bad_su_w
         $error("lpm_idle_timer: start-up delay must end before the toggle bit");
      end
   endgenerate

   pm_state_t state;
   logic      div_run;
   logic      tick;
   logic      toggle_evt;
   logic      su_done;

   assign div_run = (state != PM_HALT);

   lpm_tick_div #(
      .DIV_RATIO (DIV_RATIO)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (div_run),
      .tick  (tick)
   );

   lpm_idle_tmr #(
      .TMR_W      (TMR_W),
      .TOGGLE_BIT (TOGGLE_BIT),
      .SU_W       (SU_W)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .hold_clr   (state == PM_HALT),
      .pnd_clr    (pnd_clr),
      .en_we      (t0en_we),
      .en_wd      (t0en_wd),
      .timer      (timer_q),
      .toggle_evt (toggle_evt),
      .su_done    (su_done),
      .pnd        (t0_pnd),
      .en         (t0_en)
   );

   lpm_mode_seq #(
      .HALT_EN     (HALT_EN),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_async (wake_i),
      .idle_set   (idle_set),
      .halt_set   (halt_set),
      .toggle_evt (toggle_evt),
      .su_done    (su_done),
      .state      (state)
   );

   assign tick_o      = tick;
   assign core_clk_en = (state == PM_RUN);
   assign idle_flag_o = (state == PM_IDLE);
   assign halt_flag_o = (state == PM_HALT) || (state == PM_WARM);
   assign t0_irq      = t0_pnd && t0_en && core_clk_en;

endmodule

// File: rtl/lpm_idle_timer_chk.sv
module lpm_idle_timer_chk #(
   parameter int TMR_W      = 16,
   parameter int TOGGLE_BIT = 12,
   parameter bit HALT_EN    = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idle_set,
   input logic             halt_set,
   input logic             pnd_clr,
   input logic             tick_o,
   input logic [TMR_W-1:0] timer_q,
   input logic             t0_pnd,
   input logic             t0_irq,
   input logic             core_clk_en,
   input logic             idle_flag_o,
   input logic             halt_flag_o
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
      end
   end

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

   // R2
   timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(tick_o)) |-> (timer_q == ($past(timer_q) + TMR_W'(1))));

   // R3
   pnd_on_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(halt_flag_o) && (timer_q[TOGGLE_BIT] != $past(timer_q[TOGGLE_BIT])))
      |-> t0_pnd);

   // R4
   pnd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(pnd_clr) && (timer_q[TOGGLE_BIT] == $past(timer_q[TOGGLE_BIT])))
      |-> !t0_pnd);

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t0_irq |-> (t0_pnd && core_clk_en));

   // R6
   idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(idle_set && core_clk_en && !(halt_set && HALT_EN))) |-> idle_flag_o);

   // R9
   low_power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_flag_o || halt_flag_o) |-> !core_clk_en);

   generate
      if (!HALT_EN) begin : g_no_halt
         // R11
         never_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !halt_flag_o);
      end
   endgenerate

endmodule

bind lpm_idle_timer lpm_idle_timer_chk #(
   .TMR_W      (TMR_W),
   .TOGGLE_BIT (TOGGLE_BIT),
   .HALT_EN    (HALT_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .idle_set    (idle_set),
   .halt_set    (halt_set),
   .pnd_clr     (pnd_clr),
   .tick_o      (tick_o),
   .timer_q     (timer_q),
   .t0_pnd      (t0_pnd),
   .t0_irq      (t0_irq),
   .core_clk_en (core_clk_en),
   .idle_flag_o (idle_flag_o),
   .halt_flag_o (halt_flag_o)
);

// File: tb/test_lpm_idle_timer.sv
`timescale 1ns/1ps
module test_lpm_idle_timer;
   localparam int DIV = 10;
   localparam int SU  = 256;
   localparam int TB  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake_i = 1'b0, idle_set = 1'b0, halt_set = 1'b0, nh_halt = 1'b0;
   logic t0en_we = 1'b0, t0en_wd = 1'b0, pnd_clr = 1'b0;

   logic        tick_o, t0_pnd, t0_en, t0_irq, core_clk_en, idle_flag_o, halt_flag_o;
   logic [15:0] timer_q;
   logic        nh_tick, nh_pnd, nh_en, nh_irq, nh_core, nh_idle, nh_halt_f;
   logic [15:0] nh_timer;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   lpm_idle_timer i_lpm_idle_timer (
      .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .idle_set(idle_set), .halt_set(halt_set),
      .t0en_we(t0en_we), .t0en_wd(t0en_wd), .pnd_clr(pnd_clr),
      .tick_o(tick_o), .timer_q(timer_q), .t0_pnd(t0_pnd), .t0_en(t0_en), .t0_irq(t0_irq),
      .core_clk_en(core_clk_en), .idle_flag_o(idle_flag_o), .halt_flag_o(halt_flag_o));

   lpm_idle_timer #(.HALT_EN(1'b0)) i_lpm_idle_timer_nh (
      .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .idle_set(idle_set), .halt_set(nh_halt),
      .t0en_we(t0en_we), .t0en_wd(t0en_wd), .pnd_clr(pnd_clr),
      .tick_o(nh_tick), .timer_q(nh_timer), .t0_pnd(nh_pnd), .t0_en(nh_en), .t0_irq(nh_irq),
      .core_clk_en(nh_core), .idle_flag_o(nh_idle), .halt_flag_o(nh_halt_f));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_en(input logic v);
      t0en_we = 1'b1; t0en_wd = v;
      step(1);
      t0en_we = 1'b0;
   endtask

   task automatic clear_pnd();
      pnd_clr = 1'b1;
      step(1);
      pnd_clr = 1'b0;
   endtask

   task automatic t_reset();
      // R1
      check("R1", "core_clk_en", core_clk_en, 1);
      check("R1", "timer_q", timer_q, 0);
      check("R1", "t0_pnd", t0_pnd, 0);
      check("R1", "t0_en", t0_en, 0);
      check("R1", "t0_irq", t0_irq, 0);
      check("R1", "flags", {idle_flag_o, halt_flag_o}, 0);
   endtask

   task automatic t_tick();
      int gap;
      logic [15:0] v;
      // R2
      while (!tick_o) step(1);
      v = timer_q;
      gap = 0;
      do begin
         step(1);
         gap++;
         if (gap == 1) check("R2", "timer after tick", timer_q, int'(v) + 1);
      end while (!tick_o && gap < 50);
      check("R2", "tick spacing", gap, DIV);
   endtask

   task automatic t_idle_wake();
      logic [15:0] v;
      idle_set = 1'b1;
      step(1);
      idle_set = 1'b0;
      // R6
      check("R6", "core_clk_en in idle", core_clk_en, 0);
      check("R6", "idle_flag_o", idle_flag_o, 1);
      v = timer_q;
      step(35);
      check("R6", "timer advanced in idle", int'(timer_q - v) >= 3, 1);
      // R7
      wake_i = 1'b1;
      step(2);
      check("R7", "core_clk_en after 2 edges", core_clk_en, 0);
      step(1);
      check("R7", "core_clk_en after 3 edges", core_clk_en, 1);
      check("R7", "idle_flag_o cleared", idle_flag_o, 0);
      wake_i = 1'b0;
      step(4);
   endtask

   task automatic t_halt();
      int ticks, edges;
      halt_set = 1'b1;
      step(1);
      halt_set = 1'b0;
      // R9
      check("R9", "core_clk_en in halt", core_clk_en, 0);
      check("R9", "halt_flag_o", halt_flag_o, 1);
      ticks = 0;
      for (int i = 0; i < 40; i++) begin
         step(1);
         if (tick_o) ticks++;
      end
      check("R9", "ticks in halt", ticks, 0);
      check("R9", "timer_q held", timer_q, 0);
      // R10
      wake_i = 1'b1;
      edges = 0;
      do begin
         step(1);
         edges++;
         if (edges == 3 + DIV * SU - 1) check("R10", "halt flag before end", halt_flag_o, 1);
      end while (!core_clk_en && edges < 3000);
      wake_i = 1'b0;
      check("R10", "edges to clock enable", edges, 3 + DIV * SU);
      check("R10", "halt_flag_o after start-up", halt_flag_o, 0);
      step(2);
   endtask

   task automatic t_nohalt();
      logic [15:0] v;
      v = nh_timer;
      nh_halt = 1'b1;
      step(1);
      nh_halt = 1'b0;
      // R11
      check("R11", "core_clk_en unchanged", nh_core, 1);
      check("R11", "halt_flag_o stays 0", nh_halt_f, 0);
      step(30);
      check("R11", "timer keeps running", int'(nh_timer - v) >= 3, 1);
   endtask

   task automatic t_toggle_rise();
      logic prev, pbefore;
      int n;
      write_en(1'b1);
      prev = timer_q[TB];
      pbefore = t0_pnd;
      n = 0;
      step(1);
      while (timer_q[TB] == prev && n < 50000) begin
         pbefore = t0_pnd;
         step(1);
         n++;
      end
      // R3
      check("R3", "pnd before rise", pbefore, 0);
      check("R3", "pnd on rising toggle", t0_pnd, 1);
      // R5
      check("R5", "irq with enable", t0_irq, 1);
      clear_pnd();
      // R4
      check("R4", "pnd after clear", t0_pnd, 0);
      check("R5", "irq after clear", t0_irq, 0);
   endtask

   task automatic t_collide();
      int n;
      n = 0;
      while (!(tick_o && (&timer_q[TB-1:0])) && n < 50000) begin
         step(1);
         n++;
      end
      pnd_clr = 1'b1;
      step(1);
      pnd_clr = 1'b0;
      // R4 set wins; R3 falling toggle
      check("R4", "pnd with clear and set same edge", t0_pnd, 1);
      check("R3", "bit 12 fell", timer_q[TB], 0);
      write_en(1'b0);
      // R5
      check("R5", "irq with enable off", t0_irq, 0);
      clear_pnd();
   endtask

   task automatic t_idle_toggle(input logic en);
      int n;
      write_en(en);
      idle_set = 1'b1;
      step(1);
      idle_set = 1'b0;
      check("R8", "entered idle", idle_flag_o, 1);
      n = 0;
      while (!core_clk_en && n < 50000) begin
         step(1);
         n++;
      end
      // R8
      check("R8", "pnd with clock resume", t0_pnd, 1);
      check("R8", "low timer bits at exit", timer_q[TB-1:0], 0);
      check("R8", "irq at resume", t0_irq, en);
      check("R8", "idle flag cleared", idle_flag_o, 0);
      clear_pnd();
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_tick();
      t_idle_wake();
      t_halt();
      t_nohalt();
      t_toggle_rise();
      t_collide();
      t_idle_toggle(1'b1);
      t_idle_toggle(1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule